// File: doc/BRIEF.md
# Infrared Remote Pulse-Distance Decoder

This block turns the output of an infrared receiver module into key codes. The receiver module delivers an inverted copy of the carrier envelope: the input sits high while no carrier is present and is pulled low during each carrier burst. The decoder brings that input into the clock domain with two flip-flops and inverts it. It then times every burst and every gap. Timing is expressed in a base unit of 562.5 µs, given as a number of clock cycles by the parameter `UNIT_CYC`. The default of 28125 suits a 50 MHz clock.

A frame opens with a long header: a 16-unit burst followed by an 8-unit gap. Then come 32 data bits, sent least significant bit first. Every bit is a one-unit burst. The gap after the burst gives the bit value: one unit for a 0, three units for a 1. A final one-unit burst closes the frame. The four bytes are an address, its complement, a command and its complement. The command is kept only when the fourth byte is the exact complement of the third. In that case the command appears on `key_code` with a one-cycle `key_valid` strobe.

A header whose gap is only 4 units long is a held-key repeat. It raises `repeat_pulse` for one cycle and leaves `key_code` as it was. Any duration outside its tolerance window abandons the frame. So does a silence longer than the timeout.

Top module: `ir_pd_decoder`

## Requirements
- R1: While `rst_n` is low and after it is released, `key_code` is 0x00 and `key_valid` and `repeat_pulse` are 0.
- R2: A low level on `ir_rx` is a carrier burst and a high level is a gap; the idle level is high.
- R3: A frame starts only with a burst of 16 units followed by a gap of 8 units. Each of these durations is accepted within ±20 % inclusive, with bounds computed as floor(n·UNIT_CYC·4/5) and floor(n·UNIT_CYC·6/5).
- R4: Each data bit is a burst of 1 unit (±20 %) followed by a gap. The gap is decoded as 0 if it is shorter than 2 units and as 1 otherwise. The gap must also lie inside the 1-unit or the 3-unit ±20 % window.
- R5: Bits arrive least significant first, 32 of them. Bits 0–7 are the address, bits 8–15 the address complement, bits 16–23 the command and bits 24–31 the command complement. The frame is accepted only when bits 24–31 equal the bitwise inverse of bits 16–23. When accepted, `key_code` takes bits 16–23 and `key_valid` is high for exactly one cycle.
- R6: `key_valid` is high in the third clock cycle after the falling edge of `ir_rx` that opens the closing burst. `repeat_pulse` is high in the third cycle after the falling edge that ends a repeat header's gap.
- R7: A 16-unit burst followed by a 4-unit gap (±20 %) and a burst raises `repeat_pulse` for exactly one cycle. It leaves `key_code` unchanged and does not raise `key_valid`.
- R8: A burst or gap outside its window abandons the frame. No `key_valid` is raised and `key_code` is unchanged.
- R9: If 27 units pass with no edge while a frame is in progress, the decoder returns to idle. The next header is then decoded normally.
- R10: `key_code` changes only in a cycle where `key_valid` is high.
- R11: `key_valid` and `repeat_pulse` are never high in the same cycle.

States: IDLE waits for a burst to begin. LEAD_BURST times the header burst. LEAD_SPACE times the header gap and picks either a data frame or a repeat. DATA alternates between timing a bit burst and timing a bit gap, and shifts in one bit at the end of each gap. DONE waits for the closing burst to end. Transitions: IDLE→LEAD_BURST on a burst start. LEAD_BURST→LEAD_SPACE when the burst fits its window. LEAD_SPACE→DATA on an 8-unit gap. LEAD_SPACE→DONE on a 4-unit gap (repeat). DATA→DONE after the 32nd bit. DONE→IDLE when the burst ends. Any state other than IDLE→IDLE on an out-of-window duration or on a timeout.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ir_rx | input | 1 | Raw receiver output, low during a burst |
| key_code | output | 8 | Command byte of the last accepted frame |
| key_valid | output | 1 | One-cycle strobe marking a new accepted command |
| repeat_pulse | output | 1 | One-cycle strobe marking a repeat header |

## Verification
Each result is due a fixed three cycles after the input edge that completes it. There are two synchroniser stages, then the edge is detected and the registered strobe is set on the following clock. The bench notes the cycle number when it drives the falling edge that opens the closing burst, or that ends the repeat gap. A monitor sampling on the falling clock edge notes the cycle of each strobe, and the bench requires a difference of exactly three. For rejected or stalled frames, the bench waits out a gap longer than the timeout before it compares the strobe count and `key_code` with their earlier values.

// File: rtl/ir_pd_pkg.sv
`timescale 1ns/1ps
package ir_pd_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_LEAD_BURST,
        S_LEAD_SPACE,
        S_DATA,
        S_DONE
    } dec_state_t;

    // durations in base units (one unit = 562.5 us)
    localparam int unsigned LEAD_BURST_U = 16;
    localparam int unsigned LEAD_SPACE_U = 8;
    localparam int unsigned REP_SPACE_U  = 4;
    localparam int unsigned BIT_BURST_U  = 1;
    localparam int unsigned ZERO_SPACE_U = 1;
    localparam int unsigned ONE_SPACE_U  = 3;
    localparam int unsigned MID_SPACE_U  = 2;
    localparam int unsigned TIMEOUT_U    = 27;

    // tolerance: window is [n*4/5, n*6/5]
    localparam int unsigned TOL_LO_NUM = 4;
    localparam int unsigned TOL_HI_NUM = 6;
    localparam int unsigned TOL_DEN    = 5;

    localparam int unsigned FRAME_BITS = 32;
    localparam int unsigned KEEP_BITS  = 16;
    localparam int unsigned KEY_W      = 8;

endpackage

// File: rtl/ir_pd_front.sv
`timescale 1ns/1ps
module ir_pd_front (
    input  logic clk,
    input  logic rst_n,
    input  logic ir_rx,
    output logic burst_start,
    output logic burst_end
);
    // stage 0/1 synchronise, stage 2 holds the previous synchronised level
    logic [2:0] pipe_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= 3'b111;
        end else begin
            pipe_q <= {pipe_q[1:0], ir_rx};
        end
    end

    // input is inverted: high->low is carrier on, low->high is carrier off
    assign burst_start = pipe_q[2] & ~pipe_q[1];
    assign burst_end   = ~pipe_q[2] & pipe_q[1];
endmodule

// File: rtl/ir_pd_timer.sv
`timescale 1ns/1ps
module ir_pd_timer #(
    parameter int unsigned LIMIT = 759375,
    parameter int unsigned W     = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         restart,
    output logic [W-1:0] span,
    output logic         expired
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            span <= '0;
        end else if (restart) begin
            span <= W'(1);
        end else if (span < W'(LIMIT)) begin
            span <= span + W'(1);
        end
    end

    assign expired = (span >= W'(LIMIT));
endmodule

// File: rtl/ir_pd_window.sv
`timescale 1ns/1ps
module ir_pd_window #(
    parameter int unsigned UNITS    = 1,
    parameter int unsigned UNIT_CYC = 28125,
    parameter int unsigned W        = 20
) (
    input  logic [W-1:0] span,
    output logic         hit
);
    import ir_pd_pkg::*;

    localparam int unsigned CENTER = UNITS * UNIT_CYC;
    localparam int unsigned LO     = CENTER * TOL_LO_NUM / TOL_DEN;
    localparam int unsigned HI     = CENTER * TOL_HI_NUM / TOL_DEN;

    logic [31:0] span32;
    assign span32 = 32'(span);
    assign hit    = (span32 >= LO) && (span32 <= HI);
endmodule

// File: rtl/ir_pd_shift.sv
`timescale 1ns/1ps
module ir_pd_shift #(
    parameter int unsigned BITS = 32,
    parameter int unsigned KEEP = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            shift_en,
    input  logic            bit_in,
    output logic [KEEP-1:0] next_word,
    output logic            last_bit
);
    localparam int unsigned CW = $clog2(BITS);

    // only the newest KEEP-1 bits are stored; the incoming bit completes the word
    logic [KEEP-2:0] word_q;
    logic [CW-1:0]   cnt_q;

    assign next_word = {bit_in, word_q};
    assign last_bit  = (cnt_q == CW'(BITS - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
            cnt_q  <= '0;
        end else if (clear) begin
            cnt_q  <= '0;
        end else if (shift_en) begin
            word_q <= next_word[KEEP-1:1];
            cnt_q  <= cnt_q + CW'(1);
        end
    end
endmodule

// File: rtl/ir_pd_decoder.sv
`timescale 1ns/1ps
module ir_pd_decoder #(
    parameter int unsigned UNIT_CYC = 28125
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ir_rx,
    output logic [7:0] key_code,
    output logic       key_valid,
    output logic       repeat_pulse
);
    import ir_pd_pkg::*;

    localparam int unsigned TIMEOUT_CYC = TIMEOUT_U * UNIT_CYC;
    localparam int unsigned SPAN_W      = $clog2(TIMEOUT_CYC + 1);
    localparam int unsigned MID_CYC     = MID_SPACE_U * UNIT_CYC;
    localparam int unsigned N_WIN       = 6;
    localparam int unsigned WIN_UNITS [N_WIN] = '{LEAD_BURST_U, LEAD_SPACE_U, REP_SPACE_U,
                                                  BIT_BURST_U, ZERO_SPACE_U, ONE_SPACE_U};
    localparam int unsigned I_LB = 0;
    localparam int unsigned I_LS = 1;
    localparam int unsigned I_RS = 2;
    localparam int unsigned I_BB = 3;
    localparam int unsigned I_ZS = 4;
    localparam int unsigned I_OS = 5;

    logic              burst_start, burst_end, any_edge;
    logic [SPAN_W-1:0] span;
    logic              expired;
    logic [N_WIN-1:0]  hit;
    logic              bit_val;
    logic              sh_clear, sh_shift, last_bit;
    logic [KEEP_BITS-1:0] next_word;
    logic [KEY_W-1:0]  cmd_byte, cmd_inv;
    logic              cmd_ok;

    dec_state_t state_q, state_d;
    logic       in_space_q, in_space_d;
    logic       accept_d, rep_d;

    ir_pd_front u_front (
        .clk         (clk),
        .rst_n       (rst_n),
        .ir_rx       (ir_rx),
        .burst_start (burst_start),
        .burst_end   (burst_end)
    );

    assign any_edge = burst_start | burst_end;

    ir_pd_timer #(.LIMIT(TIMEOUT_CYC), .W(SPAN_W)) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (any_edge),
        .span    (span),
        .expired (expired)
    );

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        ir_pd_window #(.UNITS(WIN_UNITS[g]), .UNIT_CYC(UNIT_CYC), .W(SPAN_W)) u_win (
            .span (span),
            .hit  (hit[g])
        );
    end

    assign bit_val = (32'(span) >= MID_CYC);

    ir_pd_shift #(.BITS(FRAME_BITS), .KEEP(KEEP_BITS)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear     (sh_clear),
        .shift_en  (sh_shift),
        .bit_in    (bit_val),
        .next_word (next_word),
        .last_bit  (last_bit)
    );

    assign cmd_byte = next_word[KEY_W-1:0];
    assign cmd_inv  = next_word[2*KEY_W-1:KEY_W];
    assign cmd_ok   = (cmd_inv == ~cmd_byte);

    // next-state and control decode
    always_comb begin
        state_d    = state_q;
        in_space_d = in_space_q;
        sh_clear   = 1'b0;
        sh_shift   = 1'b0;
        accept_d   = 1'b0;
        rep_d      = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (burst_start) begin
                    state_d = S_LEAD_BURST;
                end
            end
            S_LEAD_BURST: begin
                if (burst_end) begin
                    state_d = hit[I_LB] ? S_LEAD_SPACE : S_IDLE;
                end else if (expired) begin
                    state_d = S_IDLE;
                end
            end
            S_LEAD_SPACE: begin
                if (burst_start) begin
                    if (hit[I_LS]) begin
                        state_d    = S_DATA;
                        sh_clear   = 1'b1;
                        in_space_d = 1'b0;
                    end else if (hit[I_RS]) begin
                        state_d = S_DONE;
                        rep_d   = 1'b1;
                    end else begin
                        state_d = S_IDLE;
                    end
                end else if (expired) begin
                    state_d = S_IDLE;
                end
            end
            S_DATA: begin
                if (burst_end) begin
                    if (!in_space_q && hit[I_BB]) begin
                        in_space_d = 1'b1;
                    end else begin
                        state_d = S_IDLE;
                    end
                end else if (burst_start) begin
                    if (in_space_q && (hit[I_ZS] || hit[I_OS])) begin
                        sh_shift   = 1'b1;
                        in_space_d = 1'b0;
                        if (last_bit) begin
                            state_d  = S_DONE;
                            accept_d = cmd_ok;
                        end
                    end else begin
                        state_d = S_IDLE;
                    end
                end else if (expired) begin
                    state_d = S_IDLE;
                end
            end
            S_DONE: begin
                if (burst_end || expired) begin
                    state_d = S_IDLE;
                end
            end
            default: begin
                state_d = S_IDLE;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= S_IDLE;
            in_space_q <= 1'b0;
        end else begin
            state_q    <= state_d;
            in_space_q <= in_space_d;
        end
    end

    // outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            key_code     <= '0;
            key_valid    <= 1'b0;
            repeat_pulse <= 1'b0;
        end else begin
            key_valid    <= accept_d;
            repeat_pulse <= rep_d;
            if (accept_d) begin
                key_code <= cmd_byte;
            end
        end
    end
endmodule

// File: rtl/ir_pd_decoder_chk.sv
`timescale 1ns/1ps
module ir_pd_decoder_chk (
    input logic                   clk,
    input logic                   rst_n,
    input logic [7:0]             key_code,
    input logic                   key_valid,
    input logic                   repeat_pulse,
    input ir_pd_pkg::dec_state_t  state_q,
    input logic                   expired,
    input logic                   burst_start,
    input logic                   burst_end
);
    import ir_pd_pkg::*;

    AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid); // R5

    AST_REPEAT_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_pulse |=> !repeat_pulse); // R7

    AST_NO_COLLIDE: assert property (@(posedge clk) disable iff (!rst_n)
        !(key_valid && repeat_pulse)); // R11

    AST_KEY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |-> $stable(key_code)); // R10

    AST_TIMEOUT_ABORT: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != S_IDLE && expired && !burst_start && !burst_end) |=> state_q == S_IDLE); // R9

    AST_VALID_FROM_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> $past(state_q) == S_DATA); // R4

    AST_IDLE_WAITS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_IDLE && !burst_start) |=> state_q == S_IDLE); // R3
endmodule

bind ir_pd_decoder ir_pd_decoder_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .key_code     (key_code),
    .key_valid    (key_valid),
    .repeat_pulse (repeat_pulse),
    .state_q      (state_q),
    .expired      (expired),
    .burst_start  (burst_start),
    .burst_end    (burst_end)
);

// File: tb/ir_pd_decoder_tb_top.sv
`timescale 1ns/1ps
module ir_pd_decoder_tb_top;
    localparam int U   = 20;
    localparam int TO  = 27 * U;
    localparam int GAP = TO + 100;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ir_rx = 1'b1;
    logic [7:0] key_code;
    logic       key_valid;
    logic       repeat_pulse;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    int vcount = 0, rcount = 0, last_vcyc = 0, last_rcyc = 0;
    int mark_cyc = 0;
    bit prev_v = 1'b0, prev_r = 1'b0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    ir_pd_decoder #(.UNIT_CYC(U)) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .ir_rx        (ir_rx),
        .key_code     (key_code),
        .key_valid    (key_valid),
        .repeat_pulse (repeat_pulse)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (key_valid) begin
                vcount++;
                last_vcyc = cyc;
                check(!prev_v, "R5", "valid longer than one cycle", 2, 1);
            end
            if (repeat_pulse) begin
                rcount++;
                last_rcyc = cyc;
                check(!prev_r, "R7", "repeat longer than one cycle", 2, 1);
            end
            if (key_valid || repeat_pulse)
                check(!(key_valid && repeat_pulse), "R11", "valid and repeat together", 1, 0);
        end
        prev_v = key_valid;
        prev_r = repeat_pulse;
    end

    function automatic int jit(input int nom);
        return nom + int'($urandom % (nom / 4 + 1)) - nom / 8;
    endfunction

    function automatic bit exp_accept(input logic [7:0] c, input logic [7:0] ci);
        return ci == ~c;
    endfunction

    task automatic hold(input bit lvl, input int n);
        ir_rx = lvl;
        repeat (n) @(negedge clk);
    endtask

    // R2: bursts are driven as low levels, gaps as high
    task automatic send_frame(input logic [7:0] a, input logic [7:0] c, input logic [7:0] ci,
                              input bit rnd, input int lb, input int lsp, input int zsp,
                              input int osp, input int bb, input int nbits);
        logic [31:0] w;
        w = {ci, c, ~a, a};
        hold(1'b0, rnd ? jit(lb) : lb);
        hold(1'b1, rnd ? jit(lsp) : lsp);
        for (int i = 0; i < nbits; i++) begin
            hold(1'b0, rnd ? jit(bb) : bb);
            if (w[i]) hold(1'b1, rnd ? jit(osp) : osp);
            else      hold(1'b1, rnd ? jit(zsp) : zsp);
        end
        if (nbits == 32) begin
            mark_cyc = cyc;
            hold(1'b0, U);
        end
        hold(1'b1, GAP);
    endtask

    task automatic frame_check(input logic [7:0] a, input logic [7:0] c, input logic [7:0] ci,
                               input bit rnd, input int lb, input int lsp, input int zsp,
                               input int osp, input int bb, input string req);
        int v0, r0;
        logic [7:0] k0;
        v0 = vcount; r0 = rcount; k0 = key_code;
        send_frame(a, c, ci, rnd, lb, lsp, zsp, osp, bb, 32);
        if (exp_accept(c, ci)) begin
            check(vcount == v0 + 1, req, "valid count", vcount - v0, 1);
            check(key_code == c, req, "key code", int'(key_code), int'(c));
            check(last_vcyc - mark_cyc == 3, "R6", "valid latency", last_vcyc - mark_cyc, 3);
        end else begin
            check(vcount == v0, "R5", "valid on bad complement", vcount - v0, 0);
            check(key_code == k0, "R10", "key changed on reject", int'(key_code), int'(k0));
        end
        check(rcount == r0, "R7", "repeat on data frame", rcount - r0, 0);
    endtask

    task automatic reject_check(input logic [7:0] c, input int lb, input int lsp,
                                input int zsp, input int osp, input int bb, input string what);
        int v0;
        logic [7:0] k0;
        v0 = vcount; k0 = key_code;
        send_frame(8'h00, c, ~c, 1'b0, lb, lsp, zsp, osp, bb, 32);
        check(vcount == v0, "R8", what, vcount - v0, 0);
        check(key_code == k0, "R8", {what, " key"}, int'(key_code), int'(k0));
    endtask

    task automatic repeat_check(input int rsp);
        int v0, r0, rs;
        logic [7:0] k0;
        v0 = vcount; r0 = rcount; k0 = key_code;
        hold(1'b0, 16 * U);
        hold(1'b1, rsp);
        rs = cyc;
        hold(1'b0, U);
        hold(1'b1, GAP);
        check(rcount == r0 + 1, "R7", "repeat count", rcount - r0, 1);
        check(last_rcyc - rs == 3, "R6", "repeat latency", last_rcyc - rs, 3);
        check(key_code == k0, "R7", "key after repeat", int'(key_code), int'(k0));
        check(vcount == v0, "R7", "valid on repeat", vcount - v0, 0);
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1234_5678));
        repeat (4) @(negedge clk);
        check(key_code == 8'h00 && !key_valid && !repeat_pulse, "R1", "in reset",
              {key_code, key_valid, repeat_pulse}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(key_code == 8'h00 && !key_valid && !repeat_pulse, "R1", "after reset",
              {key_code, key_valid, repeat_pulse}, 0);

        // directed nominal frame (R2, R4)
        frame_check(8'h00, 8'h0F, 8'hF0, 1'b0, 16*U, 8*U, U, 3*U, U, "R4");
        // upper tolerance bounds, all inclusive (R3)
        frame_check(8'h5A, 8'h1A, 8'hE5, 1'b0, 384, 192, 24, 72, 24, "R3");
        // lower tolerance bounds; zero gap just below midpoint is impossible, use 16
        frame_check(8'hA5, 8'h13, 8'hEC, 1'b0, 256, 128, 16, 48, 16, "R3");
        // bad complement (R5)
        frame_check(8'h01, 8'h13, 8'h13, 1'b0, 16*U, 8*U, U, 3*U, U, "R5");
        // repeat header at nominal and lower bound (R7)
        repeat_check(4 * U);
        repeat_check(64);
        // out-of-window durations (R8)
        reject_check(8'h07, 16*U, 193, U, 3*U, U, "header gap long");
        reject_check(8'h07, 255, 8*U, U, 3*U, U, "header burst short");
        reject_check(8'h07, 16*U, 8*U, 2*U, 2*U, U, "bit gap between windows");
        reject_check(8'h07, 16*U, 8*U, U, 3*U, 25, "bit burst long");
        // timeout of a partial frame, then a clean frame (R9)
        begin
            int v0;
            v0 = vcount;
            send_frame(8'h10, 8'h04, 8'hFB, 1'b0, 16*U, 8*U, U, 3*U, U, 10);
            check(vcount == v0, "R9", "partial frame valid", vcount - v0, 0);
            frame_check(8'h10, 8'h05, 8'hFA, 1'b0, 16*U, 8*U, U, 3*U, U, "R9");
        end
        // random frames with jitter (R2, R4, R5, R10)
        for (int n = 0; n < 12; n++) begin
            logic [7:0] a, c, ci;
            a  = 8'($urandom);
            c  = 8'($urandom % 32);
            ci = ($urandom % 4 == 0) ? 8'($urandom) : ~c;
            frame_check(a, c, ci, 1'b1, 16*U, 8*U, U, 3*U, U, "R5");
        end
        // repeat after a random burst of frames keeps the last key (R7)
        repeat_check(4 * U);

        finished = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule